// File: doc/BRIEF.md
# Write-Through Cache with Per-Word Valid Bits

This block is a direct-mapped cache that always writes through. Each line holds several one-word slots. Every slot has its own valid bit, and the line has one tag. A read hits only when the line tag matches and the addressed slot is valid. A read miss fetches just that one word from memory and installs it. A write never waits on memory. It updates the cache at once, and it also enters a small in-order write buffer that drains toward memory.

Because writes can sit in the buffer after their line has been overwritten in the cache, a read miss first searches the buffer. If the buffer holds a pending write to the same word, the newest such value is returned and installed. In that case memory is not read, so stale data never reaches the requester. A client issues one request per accepted cycle. Read results come back on a registered response port.

Top module: `wt_subblock_cache`

## Requirements
- R1: After reset every tag and every slot valid bit is clear. The response is idle, no memory request is raised, and `req_ready` is high. The first read of any word therefore goes to memory.
- R2: A read whose line tag matches and whose slot is valid returns the word with `rsp_valid` in the cycle after acceptance, and raises no memory read.
- R3: A read miss with no pending buffered write issues exactly one memory read, for the requested word address only. The other slots of the line stay as they were, so an untouched neighbour word still misses afterwards.
- R4: A write to a slot that is valid under a matching tag replaces the word and keeps the slot valid. A later read hits and returns the new data.
- R5: A write to an invalid slot under a matching tag stores the word and makes that slot valid, without any memory read.
- R6: A write whose tag differs from the line tag loads the new tag, stores the word and validates only that slot. Every other slot of the line becomes invalid, even slots that were valid before.
- R7: Writes never cause a memory read. Every accepted write reaches the memory write port exactly once, in acceptance order, with its address and data.
- R8: A read miss that matches a pending buffered write returns the youngest matching buffered data in the next cycle and raises no memory read.
- R9: While the write buffer is full, `req_ready` is low for a write request until an entry drains. Reads are not held back by a full buffer.
- R10: A read miss that goes to memory holds `mem_rd_req` and its address steady until `mem_rd_ack`. It returns `mem_rd_data` with `rsp_valid` in the cycle after the acknowledge.
- R11: Word addresses split into fields from the least significant bit upwards: the slot select (log2 WORDS bits), then the line index (log2 LINES bits), then the tag (the remaining bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted on this edge when high together with req_valid |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_data | output | DATA_W | Read data |
| mem_rd_req | output | 1 | Memory read request, held until acknowledged |
| mem_rd_addr | output | ADDR_W | Memory read word address |
| mem_rd_ack | input | 1 | Memory read done, data valid this cycle |
| mem_rd_data | input | DATA_W | Memory read data |
| mem_wr_req | output | 1 | Oldest buffered write is offered |
| mem_wr_addr | output | ADDR_W | Memory write word address |
| mem_wr_data | output | DATA_W | Memory write data |
| mem_wr_ack | input | 1 | Memory took the offered write |

## Verification
A wrong valid bit or tag shows up at the ports at the next read of that word. A slot that is wrongly valid returns old data one cycle after acceptance, with no memory read. A slot that is wrongly cleared produces an extra memory read that the memory model counts. A lost or misordered buffer entry shows up either as wrong data on a read that hits the buffer, or as a mismatch when the write reaches the memory port. The directed cases fill lines, retag them and stall the buffer. Random traffic on a small pool of colliding addresses then compares every read against a reference copy that tracks the latest written value of each word.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   typedef enum logic [0:0] {
      ST_IDLE  = 1'b0,
      ST_FETCH = 1'b1
   } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
   parameter int LINES = 8,
   parameter int WORDS = 4,
   parameter int TAG_W = 5,
   localparam int IDX_W = $clog2(LINES),
   localparam int OFF_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic [OFF_W-1:0] lk_off,
   output logic             lk_hit,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic [TAG_W-1:0] upd_tag,
   input  logic [OFF_W-1:0] upd_off
);
   logic [TAG_W-1:0] tag_q [LINES];
   logic [WORDS-1:0] vld_q [LINES];
   logic             upd_match;
   logic [WORDS-1:0] upd_bit;

   assign lk_hit    = (tag_q[lk_idx] == lk_tag) && vld_q[lk_idx][lk_off];
   assign upd_match = (tag_q[upd_idx] == upd_tag);
   assign upd_bit   = WORDS'(1) << upd_off;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) begin
            tag_q[i] <= '0;
            vld_q[i] <= '0;
         end
      end else if (upd_en) begin
         if (upd_match) begin
            vld_q[upd_idx] <= vld_q[upd_idx] | upd_bit;
         end else begin
            tag_q[upd_idx] <= upd_tag;
            vld_q[upd_idx] <= upd_bit;
         end
      end
   end

   // R5: an update always leaves its slot valid under its tag
   p_upd_validates_r5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> vld_q[$past(upd_idx)][$past(upd_off)] && (tag_q[$past(upd_idx)] == $past(upd_tag)));
   // R6: a retag leaves exactly one slot valid in the line
   p_retag_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_match) |=> ($countones(vld_q[$past(upd_idx)]) == 1));
   // R4: a matching update keeps every slot that was valid
   p_match_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_match) |=> ((vld_q[$past(upd_idx)] & $past(vld_q[upd_idx])) == $past(vld_q[upd_idx])));
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
   parameter int ENTRIES = 32,
   parameter int DATA_W  = 16,
   localparam int AW = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] mem_q [ENTRIES];

   assign rd_data = mem_q[rd_addr];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_addr] <= wr_data;
   end
endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
   parameter int AW    = 10,
   parameter int DW    = 16,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   output logic          full,
   input  logic [AW-1:0] snoop_addr,
   output logic          snoop_hit,
   output logic [DW-1:0] snoop_data,
   output logic          out_req,
   output logic [AW-1:0] out_addr,
   output logic [DW-1:0] out_data,
   input  logic          out_ack
);
   logic [AW-1:0]  addr_q [DEPTH];
   logic [DW-1:0]  data_q [DEPTH];
   logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
   logic [PTR_W:0]   cnt_q;
   logic             pop;
   logic [PTR_W-1:0] slot;

   initial assert ((1 << PTR_W) == DEPTH && DEPTH >= 2)
      else $error("wtc_wbuf: DEPTH must be a power of two, at least 2");

   assign full     = (cnt_q == (PTR_W+1)'(DEPTH));
   assign out_req  = (cnt_q != '0);
   assign out_addr = addr_q[rd_ptr_q];
   assign out_data = data_q[rd_ptr_q];
   assign pop      = out_req && out_ack;

   // oldest to newest: the last match wins, so the youngest value is returned
   always_comb begin
      snoop_hit  = 1'b0;
      snoop_data = '0;
      slot       = rd_ptr_q;
      for (int i = 0; i < DEPTH; i++) begin
         slot = rd_ptr_q + PTR_W'(i);
         if ((i < int'(cnt_q)) && (addr_q[slot] == snoop_addr)) begin
            snoop_hit  = 1'b1;
            snoop_data = data_q[slot];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push) begin
            addr_q[wr_ptr_q] <= push_addr;
            data_q[wr_ptr_q] <= push_data;
            wr_ptr_q         <= wr_ptr_q + 1'b1;
         end
         if (pop) rd_ptr_q <= rd_ptr_q + 1'b1;
         cnt_q <= cnt_q + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
      end
   end

   // R9: the producer never pushes into a full buffer
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R7: the offered head is held until memory takes it
   p_head_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_req && !out_ack) |=> out_req && $stable(out_addr) && $stable(out_data));
endmodule

// File: rtl/wt_subblock_cache.sv
module wt_subblock_cache #(
   parameter int ADDR_W   = 10,
   parameter int DATA_W   = 16,
   parameter int LINES    = 8,
   parameter int WORDS    = 4,
   parameter int WB_DEPTH = 4,
   localparam int IDX_W = $clog2(LINES),
   localparam int OFF_W = $clog2(WORDS),
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
   localparam int SLOTS = LINES * WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_ack,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   input  logic              mem_wr_ack
);
   import wtc_pkg::*;

   initial assert (TAG_W >= 1 && (1 << IDX_W) == LINES && (1 << OFF_W) == WORDS && WORDS >= 2)
      else $error("wt_subblock_cache: bad geometry parameters");

   wtc_state_e        state_q;
   logic [ADDR_W-1:0] miss_q;
   logic              lk_hit, wb_full, sn_hit;
   logic [DATA_W-1:0] sn_data, dat_rd;
   logic              acc, wr_acc, rd_acc, rd_hit, rd_snoop, rd_go, fill_mem;
   logic              upd_en;
   logic [ADDR_W-1:0] upd_addr;
   logic [DATA_W-1:0] upd_data;

   // R11: field split of a word address, slot select at the bottom
   logic [OFF_W-1:0] rq_off, up_off;
   logic [IDX_W-1:0] rq_idx, up_idx;
   logic [TAG_W-1:0] rq_tag, up_tag;
   assign rq_off = req_addr[OFF_W-1:0];
   assign rq_idx = req_addr[OFF_W +: IDX_W];
   assign rq_tag = req_addr[ADDR_W-1 -: TAG_W];
   assign up_off = upd_addr[OFF_W-1:0];
   assign up_idx = upd_addr[OFF_W +: IDX_W];
   assign up_tag = upd_addr[ADDR_W-1 -: TAG_W];

   assign req_ready = (state_q == ST_IDLE) && !(req_write && wb_full);
   assign acc       = req_valid && req_ready;
   assign wr_acc    = acc && req_write;
   assign rd_acc    = acc && !req_write;
   assign rd_hit    = rd_acc && lk_hit;
   assign rd_snoop  = rd_acc && !lk_hit && sn_hit;
   assign rd_go     = rd_acc && !lk_hit && !sn_hit;
   assign fill_mem  = (state_q == ST_FETCH) && mem_rd_ack;

   assign upd_en   = wr_acc || rd_snoop || fill_mem;
   assign upd_addr = fill_mem ? miss_q : req_addr;
   assign upd_data = wr_acc ? req_wdata : (rd_snoop ? sn_data : mem_rd_data);

   assign mem_rd_req  = (state_q == ST_FETCH);
   assign mem_rd_addr = miss_q;

   wtc_tag_store #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .lk_idx(rq_idx), .lk_tag(rq_tag), .lk_off(rq_off), .lk_hit(lk_hit),
      .upd_en(upd_en), .upd_idx(up_idx), .upd_tag(up_tag), .upd_off(up_off)
   );

   wtc_data_store #(.ENTRIES(SLOTS), .DATA_W(DATA_W)) u_data (
      .clk(clk),
      .rd_addr({rq_idx, rq_off}), .rd_data(dat_rd),
      .wr_en(upd_en), .wr_addr({up_idx, up_off}), .wr_data(upd_data)
   );

   wtc_wbuf #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
      .clk(clk), .rst_n(rst_n),
      .push(wr_acc), .push_addr(req_addr), .push_data(req_wdata), .full(wb_full),
      .snoop_addr(req_addr), .snoop_hit(sn_hit), .snoop_data(sn_data),
      .out_req(mem_wr_req), .out_addr(mem_wr_addr), .out_data(mem_wr_data),
      .out_ack(mem_wr_ack)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         miss_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= rd_hit || rd_snoop || fill_mem;
         if (rd_hit)        rsp_data <= dat_rd;
         else if (rd_snoop) rsp_data <= sn_data;
         else if (fill_mem) rsp_data <= mem_rd_data;
         if (rd_go) begin
            state_q <= ST_FETCH;
            miss_q  <= req_addr;
         end else if (fill_mem) begin
            state_q <= ST_IDLE;
         end
      end
   end

   // R2: a hit answers next cycle and never starts a fetch
   p_hit_no_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> rsp_valid && !mem_rd_req);
   // R7: an accepted write never starts a fetch
   p_write_no_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> !mem_rd_req);
   // R8: a buffer match answers without a fetch
   p_snoop_no_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_snoop |=> rsp_valid && !mem_rd_req);
   // R9: full buffer blocks writes only
   p_full_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_write && wb_full) |-> !req_ready);
   // R10: fetch request held steady until acknowledged
   p_fetch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_ack) |=> mem_rd_req && $stable(mem_rd_addr));
   // R10: acknowledged data is returned the next cycle
   p_fill_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && mem_rd_ack) |=> rsp_valid && (rsp_data == $past(mem_rd_data)));
endmodule

// File: tb/tb_wt_subblock_cache.sv
module tb_wt_subblock_cache;
   localparam int AW = 10;
   localparam int DW = 16;
   localparam int NW = 1 << AW;
   localparam int RD_LAT = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_valid, mem_rd_req, mem_wr_req;
   logic [DW-1:0] rsp_data, mem_wr_data;
   logic [AW-1:0] mem_rd_addr, mem_wr_addr;
   logic mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
   logic [DW-1:0] mem_rd_data = '0;

   always #10 clk = ~clk;  // 50 MHz

   wt_subblock_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(8), .WORDS(4), .WB_DEPTH(4)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
      .mem_rd_data(mem_rd_data),
      .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_wr_ack(mem_wr_ack)
   );

   int checks = 0, fails = 0, cyc = 0;
   logic [DW-1:0] ext_mem  [NW];
   logic [DW-1:0] gold_mem [NW];
   logic [AW-1:0] log_a [1024];
   logic [DW-1:0] log_d [1024];
   int n_log = 0, wr_seen = 0, rd_cnt = 0, ack_cyc = 0, rd_wait = 0;
   bit wr_ack_en = 1'b1, rnd_mode = 1'b0;

   function automatic logic [DW-1:0] init_val(input int a);
      return DW'(a * 37 + 5);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // memory model, driven away from the active edge
   always @(negedge clk) begin
      if (mem_rd_ack) mem_rd_ack = 1'b0;
      else if (rst_n && mem_rd_req) begin
         if (rd_wait >= RD_LAT) begin
            mem_rd_ack  = 1'b1;
            mem_rd_data = ext_mem[mem_rd_addr];
            rd_cnt++;
            ack_cyc = cyc;
            rd_wait = 0;
         end else rd_wait++;
      end
      if (mem_wr_ack) mem_wr_ack = 1'b0;
      else if (rst_n && mem_wr_req && wr_ack_en && (!rnd_mode || ($urandom % 2 == 0))) begin
         // R7: order, address and data of every write at the memory port
         chk(mem_wr_addr == log_a[wr_seen % 1024] && mem_wr_data == log_d[wr_seen % 1024],
             "R7 write order", int'({mem_wr_addr, mem_wr_data}),
             int'({log_a[wr_seen % 1024], log_d[wr_seen % 1024]}));
         ext_mem[mem_wr_addr] = mem_wr_data;
         wr_seen++;
         mem_wr_ack = 1'b1;
      end
   end

   task automatic issue(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d, output int acc_c);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      acc_c = cyc;
      if (w) begin
         gold_mem[a] = d;
         log_a[n_log % 1024] = a;
         log_d[n_log % 1024] = d;
         n_log++;
      end
      @(posedge clk); #1;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      int c;
      issue(1'b1, a, d, c);
   endtask

   // exp_reads: -1 = do not check the memory read count
   task automatic rd(input logic [AW-1:0] a, input int exp_reads, input string req);
      int c, r0, n, rc;
      bit got;
      r0 = rd_cnt;
      got = 1'b0;
      rc = 0;
      issue(1'b0, a, '0, c);
      for (int k = 0; k < 40 && !got; k++) begin
         @(negedge clk);
         if (rsp_valid) begin got = 1'b1; rc = cyc; end
      end
      chk(got && rsp_data == gold_mem[a], req, int'(rsp_data), int'(gold_mem[a]));
      n = rd_cnt - r0;
      if (exp_reads >= 0) chk(n == exp_reads, {req, " mem reads"}, n, exp_reads);
      if (n == 0) chk(rc == c + 1, {req, " hit latency"}, rc, c + 1);
      else        chk(rc == ack_cyc + 1, "R10 fill latency", rc, ack_cyc + 1);
   endtask

   task automatic drain();
      for (int k = 0; k < 100 && mem_wr_req; k++) @(negedge clk);
   endtask

   initial begin
      logic [AW-1:0] A, B, C1, C2, D, E;
      int r_before;
      for (int i = 0; i < NW; i++) begin
         ext_mem[i]  = init_val(i);
         gold_mem[i] = init_val(i);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1: reset state at the ports
      chk(!rsp_valid && !mem_rd_req && !mem_wr_req && req_ready, "R1 reset state",
          int'({rsp_valid, mem_rd_req, mem_wr_req, req_ready}), 1);

      // R11: addr = {tag, idx[2:0], slot[1:0]}
      A = 10'h040;                 // tag 2, line 0, slot 0
      B = A + 10'd32;              // tag 3, line 0, slot 0
      rd(A, 1, "R1 first read misses");
      rd(A, 0, "R2 read hit");
      rd(A + 10'd1, 1, "R3 neighbour fetch");
      rd(A + 10'd3, 1, "R3 untouched slot still misses");
      r_before = rd_cnt;
      wr(A + 10'd2, 16'hBEEF);
      rd(A + 10'd2, 0, "R5 write validates slot");
      wr(A, 16'h1234);
      rd(A, 0, "R4 write on valid slot");
      chk(rd_cnt == r_before, "R7 writes read no memory", rd_cnt - r_before, 0);
      drain();
      wr(B, 16'h5A5A);
      drain();
      rd(B, 0, "R6 retagged slot hits");
      rd(A + 10'd1, 1, "R6 other slot cleared");
      rd(A + 10'd2, 1, "R6 written slot cleared by retag");

      // R8 and R9 with memory writes held off
      C1 = 10'h0A5; C2 = C1 + 10'd32; D = 10'h0E6; E = 10'h111;
      wr_ack_en = 1'b0;
      wr(C1, 16'h0111);
      wr(C1, 16'h0222);
      wr(C2, 16'h0333);
      wr(D, 16'h0444);
      rd(C1, 0, "R8 youngest buffered data");
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = E; req_wdata = 16'h0555;
      for (int k = 0; k < 3; k++) begin
         #1;
         chk(!req_ready, "R9 full buffer stalls write", int'(req_ready), 0);
         @(negedge clk);
      end
      req_write = 1'b0; #1;
      chk(req_ready, "R9 read not blocked by full buffer", int'(req_ready), 1);
      req_valid = 1'b0;
      wr_ack_en = 1'b1;
      wr(E, 16'h0555);
      chk(1'b1, "R9 write accepted after drain", 1, 1);
      drain();
      chk(wr_seen == n_log, "R7 every write reached memory", wr_seen, n_log);
      rd(E, 0, "R4 drained write still cached");

      // random traffic on a colliding address pool
      rnd_mode = 1'b1;
      void'($urandom(32'd12345));
      for (int n = 0; n < 400; n++) begin
         logic [AW-1:0] a;
         a = AW'(((1 + $urandom % 2) << 5) | (($urandom % 2) << 2) | ($urandom % 4));
         if ($urandom % 2 == 0) wr(a, DW'($urandom));
         else rd(a, -1, "R10 random read data");
      end
      rnd_mode = 1'b0;
      drain();
      chk(wr_seen == n_log, "R7 random writes all reached memory", wr_seen, n_log);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule